// File: doc/BRIEF.md
# Capture Ring Buffer Producer

This block takes a stream of 32-bit audio sample words and writes them into a circular buffer in memory. It is the hardware producer of a ring that software drains. Both sides track their position as a byte offset from the buffer base. The block owns the producer offset and advances it after each word is stored. Software owns the consumer offset and writes it through the register port once it has read data out of the ring.

The ring is never allowed to become completely full. If storing one more word would move the producer offset onto the consumer offset, the block holds off, and it resumes once software moves the consumer offset. A sample that arrives while the block cannot take it is discarded, and a sticky overflow flag records the loss.

Each acknowledged word counts as one frame. A programmable period length sets how many frames make one period. At the end of each period the block sends a single-cycle pulse to the shared interrupt unit. A soft reset returns the producer side to its starting state without disturbing the configuration.

Top module: `cap_ring_producer`

## Requirements
- R1: After reset, the enable register (0x14), the producer offset (0x20) and the overflow flag (0x30) all read 0, `mem_req` is low and `period_irq` is low.
- R2: When bit 0 of 0x14 is 1 and the ring has room, a sample presented with `smp_valid` starts one memory write. The write uses address = base (0x18) + producer offset and carries the sample word unchanged. `mem_req`, `mem_addr` and `mem_data` stay constant until `mem_ack` is sampled high.
- R3: Each acknowledged write advances the producer offset by 4, modulo the buffer size in bytes (0x1C, a power of two). Software reads the producer offset at 0x20.
- R4: No write starts while (producer offset + 4) mod size equals the consumer offset (0x24). Writing to the consumer offset affects this decision from the following clock edge onward.
- R5: A sample that arrives while enabled, but while the ring is stalled or a write is still outstanding, is dropped. The drop sets a sticky overflow flag, read as bit 0 of 0x30.
- R6: While bit 0 of 0x14 is 0, samples start no write and do not set the overflow flag.
- R7: Writing 1 to bit 0 of 0x2C clears the producer offset, the frame counter and the overflow flag. If a write is outstanding at that point, or is acknowledged on that same edge, its acknowledgement does not advance the offset. A sample presented on the soft-reset cycle is discarded and does not set the overflow flag.
- R8: The config word at 0x4C holds the period length in frames in bits [31:8] and the interrupt enable in bit 0. When the count of acknowledged writes reaches a nonzero period length, the counter returns to 0 and `period_irq` is high for exactly one cycle: the cycle after the acknowledging edge. A period length of 0 never produces a pulse.
- R9: When bit 0 of 0x4C is 0, the frame counter still counts and wraps, but `period_irq` stays low.
- R10: Registers 0x18, 0x1C, 0x24 and 0x4C read back the value last written to them. Size and consumer offset are kept to 22 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| smp_valid | input | 1 | Incoming sample is present this cycle |
| smp_data | input | 32 | Incoming 32-bit sample word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write accepted |
| period_irq | output | 1 | One-cycle period pulse to the interrupt unit |

## Verification
Two situations can collide in a single cycle. In the first, a soft reset lands on the same edge as the acknowledgement of an outstanding write. The bench holds the acknowledge back, then raises the acknowledge and the soft-reset write together. It then requires the producer offset to read 0 and a following write to start again from offset 0. In the second, a consumer-offset write arrives together with a sample while the ring is stalled. The bench requires that sample to be dropped, because the old consumer offset still governs that edge, and the next sample to be stored. A cycle-by-cycle model in the bench also checks the request, address, data and period pulse on every clock.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned REG_AW       = 8;
  localparam int unsigned SMP_W        = 32;
  localparam int unsigned SAMPLE_BYTES = SMP_W / 8;
  localparam int unsigned PER_LSB      = 8;
  localparam int unsigned PER_W        = REG_W - PER_LSB;

  localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h14;
  localparam logic [REG_AW-1:0] OFS_BASE   = 8'h18;
  localparam logic [REG_AW-1:0] OFS_SIZE   = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_PROD   = 8'h20;
  localparam logic [REG_AW-1:0] OFS_CONS   = 8'h24;
  localparam logic [REG_AW-1:0] OFS_SRST   = 8'h2C;
  localparam logic [REG_AW-1:0] OFS_OVF    = 8'h30;
  localparam logic [REG_AW-1:0] OFS_IRQCFG = 8'h4C;
endpackage

// File: rtl/cap_ring_regs.sv
module cap_ring_regs
  import cap_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SZ_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [SZ_W-1:0]   prod_idx,
  input  logic              ovf,
  output logic              en,
  output logic [ADDR_W-1:0] base,
  output logic [SZ_W-1:0]   size,
  output logic [SZ_W-1:0]   cons,
  output logic [PER_W-1:0]  per_len,
  output logic              irq_en,
  output logic              srst
);

  logic              en_q, irq_en_q;
  logic [ADDR_W-1:0] base_q;
  logic [SZ_W-1:0]   size_q, cons_q;
  logic [PER_W-1:0]  per_len_q;
  logic              we_en, we_base, we_size, we_cons, we_cfg;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;

  // write decode (clock enables)
  always_comb begin
    we_en   = reg_we && (reg_addr == OFS_ENABLE);
    we_base = reg_we && (reg_addr == OFS_BASE);
    we_size = reg_we && (reg_addr == OFS_SIZE);
    we_cons = reg_we && (reg_addr == OFS_CONS);
    we_cfg  = reg_we && (reg_addr == OFS_IRQCFG);
    srst    = reg_we && (reg_addr == OFS_SRST) && reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      base_q    <= '0;
      size_q    <= '0;
      cons_q    <= '0;
      per_len_q <= '0;
      irq_en_q  <= 1'b0;
    end else begin
      if (we_en)   en_q      <= reg_wdata[0];
      if (we_base) base_q    <= reg_wdata[ADDR_W-1:0];
      if (we_size) size_q    <= reg_wdata[SZ_W-1:0];
      if (we_cons) cons_q    <= reg_wdata[SZ_W-1:0];
      if (we_cfg)  per_len_q <= reg_wdata[REG_W-1:PER_LSB];
      if (we_cfg)  irq_en_q  <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_ENABLE: reg_rdata[0]         = en_q;
      OFS_BASE:   reg_rdata            = REG_W'(base_q);
      OFS_SIZE:   reg_rdata            = REG_W'(size_q);
      OFS_PROD:   reg_rdata            = REG_W'(prod_idx);
      OFS_CONS:   reg_rdata            = REG_W'(cons_q);
      OFS_OVF:    reg_rdata[0]         = ovf;
      OFS_IRQCFG: reg_rdata            = {per_len_q, {(PER_LSB-1){1'b0}}, irq_en_q};
      default:    reg_rdata            = '0;
    endcase
  end

  assign en      = en_q;
  assign base    = base_q;
  assign size    = size_q;
  assign cons    = cons_q;
  assign per_len = per_len_q;
  assign irq_en  = irq_en_q;

endmodule

// File: rtl/cap_ring_ptr.sv
module cap_ring_ptr
  import cap_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SZ_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [SZ_W-1:0]   size,
  input  logic [SZ_W-1:0]   cons,
  input  logic              srst,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SMP_W-1:0]  mem_data,
  input  logic              mem_ack,
  output logic [SZ_W-1:0]   prod_idx,
  output logic              ovf,
  output logic              adv
);

  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q;
  logic [SMP_W-1:0]  data_q;
  logic [SZ_W-1:0]   prod_q, prod_d;
  logic              ovf_q, ovf_d;
  logic              flush_q, flush_d;
  logic [SZ_W-1:0]   mask, step_idx;
  logic              full, accept, drop, done, prod_en;

  always_comb begin
    mask     = size - SZ_W'(1);
    step_idx = (prod_q + SZ_W'(SAMPLE_BYTES)) & mask;
    full     = (step_idx == (cons & mask));
    done     = req_q && mem_ack;
    accept   = smp_valid && en && !req_q && !full && !srst;
    drop     = smp_valid && en && !accept;
    adv      = done && !flush_q && !srst;
    prod_en  = srst || adv;
    prod_d   = srst ? '0 : step_idx;
    ovf_d    = srst ? 1'b0 : (ovf_q || drop);

    req_d = req_q;
    if (done)   req_d = 1'b0;
    if (accept) req_d = 1'b1;

    flush_d = flush_q;
    if (srst && req_q && !mem_ack) flush_d = 1'b1;
    else if (done)                 flush_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      prod_q  <= '0;
      ovf_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      ovf_q   <= ovf_d;
      flush_q <= flush_d;
      if (accept) begin
        addr_q <= base + ADDR_W'(prod_q);
        data_q <= smp_data;
      end
      if (prod_en) prod_q <= prod_d;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign mem_data = data_q;
  assign prod_idx = prod_q;
  assign ovf      = ovf_q;

endmodule

// File: rtl/cap_ring_period.sv
module cap_ring_period
  import cap_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             srst,
  input  logic [PER_W-1:0] per_len,
  input  logic             irq_en,
  output logic             irq
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             wrap, cnt_en;

  always_comb begin
    wrap   = (per_len != '0) && ((cnt_q + PER_W'(1)) == per_len);
    cnt_en = srst || adv;
    if (srst)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + PER_W'(1);
    irq_d  = adv && wrap && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/cap_ring_producer.sv
module cap_ring_producer
  import cap_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SZ_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SMP_W-1:0]  mem_data,
  input  logic              mem_ack,
  output logic              period_irq
);

  logic              en_w, irq_en_w, srst_w, ovf_w, adv_w;
  logic [ADDR_W-1:0] base_w;
  logic [SZ_W-1:0]   size_w, cons_w, prod_w;
  logic [PER_W-1:0]  per_len_w;

  cap_ring_regs #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .prod_idx (prod_w),
    .ovf      (ovf_w),
    .en       (en_w),
    .base     (base_w),
    .size     (size_w),
    .cons     (cons_w),
    .per_len  (per_len_w),
    .irq_en   (irq_en_w),
    .srst     (srst_w)
  );

  cap_ring_ptr #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_w),
    .base     (base_w),
    .size     (size_w),
    .cons     (cons_w),
    .srst     (srst_w),
    .smp_valid(smp_valid),
    .smp_data (smp_data),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .mem_ack  (mem_ack),
    .prod_idx (prod_w),
    .ovf      (ovf_w),
    .adv      (adv_w)
  );

  cap_ring_period u_period (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv_w),
    .srst   (srst_w),
    .per_len(per_len_w),
    .irq_en (irq_en_w),
    .irq    (period_irq)
  );

endmodule

// File: rtl/cap_ring_producer_chk.sv
module cap_ring_producer_chk
  import cap_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SZ_W   = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [SMP_W-1:0]  mem_data,
  input logic              period_irq,
  input logic              en,
  input logic              srst,
  input logic              ovf,
  input logic [SZ_W-1:0]   prod_idx,
  input logic [SZ_W-1:0]   cons_idx,
  input logic [SZ_W-1:0]   ring_size
);

  logic [SZ_W-1:0] mask;
  assign mask = ring_size - SZ_W'(1);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data)); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prod_idx) |-> (prod_idx == '0) ||
      (prod_idx == (($past(prod_idx) + SZ_W'(SAMPLE_BYTES)) & $past(mask)))); // R3

  AST_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(((prod_idx + SZ_W'(SAMPLE_BYTES)) & mask) != (cons_idx & mask))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !srst |=> ovf); // R5

  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(en)); // R6

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (prod_idx == '0) && !ovf); // R7

  AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq |-> $past(mem_req && mem_ack)); // R8

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq |=> !period_irq); // R8

endmodule

bind cap_ring_producer cap_ring_producer_chk #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .period_irq(period_irq),
  .en        (en_w),
  .srst      (srst_w),
  .ovf       (ovf_w),
  .prod_idx  (prod_w),
  .cons_idx  (cons_w),
  .ring_size (size_w)
);

// File: tb/cap_ring_producer_test.sv
`timescale 1ns/1ps
module cap_ring_producer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        smp_valid;
  logic [31:0] smp_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_ack;
  logic        period_irq;
  logic        auto_ack, ack_now;

  int tests = 0;
  int fails = 0;
  int irq_seen = 0;

  always #2 clk = ~clk;

  assign mem_ack = mem_req && (auto_ack || ack_now);

  cap_ring_producer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ack(mem_ack), .period_irq(period_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_en, m_size, m_cons, m_prod, m_ovf, m_req, m_flush, m_cnt, m_len, m_ien, m_irq;
  logic [31:0] m_base, m_addr, m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_size = 0; m_cons = 0; m_prod = 0; m_ovf = 0; m_req = 0;
      m_flush = 0; m_cnt = 0; m_len = 0; m_ien = 0; m_irq = 0;
      m_base = 0; m_addr = 0; m_data = 0;
    end else begin
      int mask;
      bit s_rst, done, full, acc, drop, adv;
      mask  = (m_size - 1) & 32'h003F_FFFF;
      s_rst = reg_we && reg_addr == 8'h2C && reg_wdata[0];
      done  = (m_req != 0) && mem_ack;
      full  = ((m_prod + 4) & mask) == (m_cons & mask);
      acc   = smp_valid && m_en != 0 && m_req == 0 && !full && !s_rst;
      drop  = smp_valid && m_en != 0 && !acc;
      adv   = done && m_flush == 0 && !s_rst;
      m_irq = 0;
      if (acc) begin
        m_addr = m_base + 32'(m_prod);
        m_data = smp_data;
      end
      if (adv) begin
        m_prod = (m_prod + 4) & mask;
        if (m_len != 0 && m_cnt + 1 == m_len) begin
          m_cnt = 0;
          m_irq = m_ien;
        end else m_cnt++;
      end
      if (s_rst && m_req != 0 && !mem_ack) m_flush = 1;
      else if (done) m_flush = 0;
      if (s_rst) begin m_prod = 0; m_cnt = 0; m_ovf = 0; end
      else if (drop) m_ovf = 1;
      if (done) m_req = 0;
      if (acc) m_req = 1;
      if (reg_we) begin
        case (reg_addr)
          8'h14: m_en   = int'(reg_wdata[0]);
          8'h18: m_base = reg_wdata;
          8'h1C: m_size = int'(reg_wdata & 32'h003F_FFFF);
          8'h24: m_cons = int'(reg_wdata & 32'h003F_FFFF);
          8'h4C: begin m_len = int'(reg_wdata >> 8); m_ien = int'(reg_wdata[0]); end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 mem_req", {31'b0, mem_req}, 32'(m_req));
      if (m_req != 0) begin
        chk("R2 mem_addr", mem_addr, m_addr);
        chk("R2 mem_data", mem_data, m_data);
      end
      chk("R8 period_irq", {31'b0, period_irq}, 32'(m_irq));
      if (period_irq) irq_seen++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic send(input logic [31:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int k;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h0; reg_wdata = 32'h0;
    smp_valid = 1'b0; smp_data = 32'h0; auto_ack = 1'b0; ack_now = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 enable", 8'h14, 32'h0);
    rd_chk("R1 prod", 8'h20, 32'h0);
    rd_chk("R1 ovf", 8'h30, 32'h0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
    chk("R1 irq", {31'b0, period_irq}, 32'h0);

    // configure: 64-byte ring, period 4, irq on
    wr(8'h18, 32'h1000_0000);
    wr(8'h1C, 32'd64);
    wr(8'h24, 32'd0);
    wr(8'h4C, (32'd4 << 8) | 32'd1);
    wr(8'h14, 32'd1);
    auto_ack = 1'b1;
    rd_chk("R10 base", 8'h18, 32'h1000_0000);
    rd_chk("R10 size", 8'h1C, 32'd64);
    rd_chk("R10 cons", 8'h24, 32'd0);
    rd_chk("R10 cfg", 8'h4C, 32'h0000_0401);

    for (int i = 0; i < 10; i++) begin send(32'hA500_0000 + i); idle(2); end
    rd_chk("R3 prod after 10", 8'h20, 32'd40);
    chk("R8 pulses after 10", 32'(irq_seen), 32'd2);

    // fill to the stall point and beyond
    for (int i = 0; i < 10; i++) begin send(32'hB600_0000 + i); idle(2); end
    rd_chk("R4 prod stalled", 8'h20, 32'd60);
    rd_chk("R5 overflow", 8'h30, 32'd1);

    // consumer moves, producer wraps
    wr(8'h24, 32'd32);
    for (int i = 0; i < 3; i++) begin send(32'hC700_0000 + i); idle(2); end
    rd_chk("R3 prod wrapped", 8'h20, 32'd8);
    chk("R8 pulses after 18", 32'(irq_seen), 32'd4);
    rd_chk("R5 overflow sticky", 8'h30, 32'd1);

    // soft reset with an outstanding write
    auto_ack = 1'b0;
    send(32'hD800_0001);
    idle(1);
    wr(8'h2C, 32'd1);
    idle(1);
    ack_now = 1'b1;
    @(negedge clk);
    ack_now = 1'b0;
    idle(2);
    rd_chk("R7 prod after srst", 8'h20, 32'd0);
    rd_chk("R7 ovf after srst", 8'h30, 32'd0);

    // soft reset on the same edge as an acknowledge
    auto_ack = 1'b1;
    send(32'hE900_0001); idle(2);
    send(32'hE900_0002); idle(2);
    rd_chk("R3 prod before clash", 8'h20, 32'd8);
    auto_ack = 1'b0;
    send(32'hE900_0003);
    idle(1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h2C; reg_wdata = 32'd1; ack_now = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; ack_now = 1'b0;
    idle(2);
    rd_chk("R7 prod after clash", 8'h20, 32'd0);
    chk("R7 req cleared", {31'b0, mem_req}, 32'h0);
    auto_ack = 1'b1;
    send(32'hE900_0004); idle(2);
    rd_chk("R7 restart from 0", 8'h20, 32'd4);

    // consumer write together with a sample while stalled
    wr(8'h24, 32'd8);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h24; reg_wdata = 32'd40;
    smp_valid = 1'b1; smp_data = 32'hF000_0001;
    @(negedge clk);
    reg_we = 1'b0; smp_valid = 1'b0;
    idle(2);
    rd_chk("R4 same-cycle dropped", 8'h20, 32'd4);
    rd_chk("R5 same-cycle ovf", 8'h30, 32'd1);
    send(32'hF000_0002); idle(2);
    rd_chk("R4 resumed", 8'h20, 32'd8);

    // disabled: samples ignored
    wr(8'h2C, 32'd1);
    wr(8'h14, 32'd0);
    k = irq_seen;
    for (int i = 0; i < 3; i++) begin send(32'h1111_0000 + i); idle(2); end
    rd_chk("R6 prod unchanged", 8'h20, 32'd0);
    rd_chk("R6 no overflow", 8'h30, 32'd0);
    chk("R6 no pulse", 32'(irq_seen), 32'(k));
    wr(8'h14, 32'd1);

    // interrupt disabled: counter still wraps
    wr(8'h4C, (32'd2 << 8));
    k = irq_seen;
    for (int i = 0; i < 4; i++) begin send(32'h2222_0000 + i); idle(2); end
    chk("R9 no pulse while masked", 32'(irq_seen), 32'(k));
    wr(8'h4C, (32'd2 << 8) | 32'd1);
    for (int i = 0; i < 2; i++) begin send(32'h3333_0000 + i); idle(2); end
    chk("R8 pulse after unmask", 32'(irq_seen), 32'(k + 1));

    // period length zero
    wr(8'h4C, 32'd1);
    k = irq_seen;
    for (int i = 0; i < 3; i++) begin send(32'h4444_0000 + i); idle(2); end
    chk("R8 zero length no pulse", 32'(irq_seen), 32'(k));
    rd_chk("R3 prod final", 8'h20, 32'd36);

    idle(2);
    summary();
  end

endmodule